// File: doc/BRIEF.md
# Physical-Layer Control Write Decoder

This block sits on the control side of a DDR memory interface and turns single-word bus writes (an address, a data word and a write strobe) into the control state the physical layer needs. Every address is compared against three regions. Each region is defined by a base and a mask, and both are parameters. A write hits a region when the address bits selected by the mask are equal to the base.

The first region starts the command sequencer. A write there produces a one-cycle run pulse, and the low address bits of that write give the channel number. The second region carries no data: each pair of addresses in it drives one level flag, where the even address clears the flag and the odd address sets it, and the lowest address of the region fires a one-cycle pulse that loads the preset delays. The third region holds a small bank of short data registers: a data-strobe pattern, a tristate timing pattern, an extra read-buffer delay, a clock-divider invert option and a status-control byte that also gives a write strobe.

Top module: `phy_ctrl_decoder`

## Requirements
- R1: A write matches a region when ((address XOR base) AND mask) is zero. The default bases and masks are: run region 'h000/'h3f0, flag region 'h020/'h3f0, data region 'h050/'h3f8. If regions overlap, priority is run, then flag, then data. A write that matches no region changes no output and raises no pulse.
- R2: A write into the run region raises `run_pulse` in the cycle after the write. In that same cycle `run_chan` equals address bits [3:0] of the write.
- R3: `run_pulse` is high only in cycles that directly follow a run-region write. `run_chan` holds its value until the next run-region write.
- R4: In the flag region, address offset bits [3:1] select a flag and bit 0 gives its new value (0 clears, 1 sets): offsets 4/5 command/address enable, 6/7 memory reset active, 8/9 CKE enable, a/b impedance-calibration reset, c/d delay-calibration reset. `mem_rst_n` is the inverse of the memory-reset-active flag.
- R5: A write to offset 0 of the flag region raises `dly_preset_pulse` for exactly the next cycle and changes no flag.
- R6: After reset every flag is inactive except memory reset, which is active (`mem_rst_n` = 0). `dq_pattern` = 16'h0055, all other registers are 0, and all pulses are low.
- R7: Offset 0 of the data region loads `dq_pattern` from data[15:0].
- R8: Offset 1 of the data region loads `tri_pattern` from data[15:0]. The fields are [15:12] strobe-off, [11:8] strobe-on, [7:4] data-off and [3:0] data-on.
- R9: Offset 2 loads `rbuf_extra_dly` from data[3:0]. Offset 3 loads `clk_div_inv` from data[0].
- R10: Offset 4 loads `stat_ctrl` from data[7:0] and raises `stat_ctrl_stb` for exactly the next cycle.
- R11: Unused offsets are ignored: offsets 1, 2, 3, e and f of the flag region, and offsets 5 to 7 of the data region.
- R12: All outputs change on the first clock edge that samples the write strobe, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe, valid for one cycle per write |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| run_pulse | output | 1 | One-cycle sequencer start |
| run_chan | output | CHAN_W | Channel for the sequencer start |
| dly_preset_pulse | output | 1 | One-cycle load of the preset delays |
| cmda_en | output | 1 | Command/address output enable |
| mem_rst_n | output | 1 | Active-low memory reset |
| cke_en | output | 1 | Clock-enable drive enable |
| zq_cal_rst | output | 1 | Impedance-calibration reset |
| dly_cal_rst | output | 1 | Delay-calibration reset |
| dq_pattern | output | 16 | Data-mask and strobe pattern |
| tri_pattern | output | 16 | Tristate on/off timing pattern |
| rbuf_extra_dly | output | 4 | Extra read-buffer enable delay, in cycles |
| clk_div_inv | output | 1 | Clock-divider invert option |
| stat_ctrl | output | 8 | Status-control value |
| stat_ctrl_stb | output | 1 | One-cycle strobe on a status-control write |

## Verification
The bench writes every address in the flag region, both parities and the unused offsets among them. A decoder that looked at the data word, or that got the pair order wrong, would move the wrong flag or leave the right one unchanged. It sends run writes to channels 0 and 15 and sends back-to-back run writes. A pulse that is stretched, or a channel that is sampled one cycle late, shows up as a mismatch in the cycle after the write. It also writes addresses just outside each region's mask and the unused data offsets, where a decoder that skips a mask bit would corrupt a register. It checks the reset values too, which catches a memory reset that is released at power-up or a pattern that powers up as zero.

// File: rtl/phy_ctrl_pkg.sv
`timescale 1ns/1ps
package phy_ctrl_pkg;
  localparam int NUM_FLAGS = 5;
  // flag slots: index k sits at region offsets 2k+4 (clear) and 2k+5 (set)
  typedef enum logic [2:0] {
    FL_CMDA   = 3'd0,
    FL_MEMRST = 3'd1,
    FL_CKE    = 3'd2,
    FL_ZQRST  = 3'd3,
    FL_DLYRST = 3'd4
  } flag_idx_e;

  function automatic logic region_hit(input logic [15:0] addr,
                                      input logic [15:0] base,
                                      input logic [15:0] mask);
    return ((addr ^ base) & mask) == 16'h0;
  endfunction
endpackage

// File: rtl/ctrl_rst_sync.sv
`timescale 1ns/1ps
module ctrl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/ctrl_addr_match.sv
`timescale 1ns/1ps
module ctrl_addr_match #(
  parameter int          ADDR_W = 10,
  parameter logic [15:0] BASE   = 16'h000,
  parameter logic [15:0] MASK   = 16'h3f0
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  import phy_ctrl_pkg::*;
  assign hit = en && region_hit(16'(addr), BASE, MASK);
endmodule

// File: rtl/ctrl_flag_bank.sv
`timescale 1ns/1ps
module ctrl_flag_bank #(
  parameter int             NUM     = 5,
  parameter logic [NUM-1:0] RST_VAL = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel,
  input  logic [3:0]     offs,
  output logic [NUM-1:0] flags,
  output logic           preset_pulse
);
  localparam int FIRST_PAIR = 2;

  logic preset_nxt;
  assign preset_nxt = sel && (offs == 4'h0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) preset_pulse <= 1'b0;
    else        preset_pulse <= preset_nxt;
  end

  for (genvar k = 0; k < NUM; k++) begin : g_flag
    logic flag_q, flag_nxt, flag_we;
    assign flag_we = sel && (offs[3:1] == 3'(k + FIRST_PAIR));

    always_comb begin
      flag_nxt = flag_q;
      if (flag_we) flag_nxt = offs[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= RST_VAL[k];
      else        flag_q <= flag_nxt;
    end

    assign flags[k] = flag_q;
  end
endmodule

// File: rtl/ctrl_data_regs.sv
`timescale 1ns/1ps
module ctrl_data_regs #(
  parameter int          DATA_W      = 16,
  parameter logic [15:0] PATTERN_RST = 16'h0055
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [2:0]        offs,
  input  logic [DATA_W-1:0] wdata,
  output logic [15:0]       dq_pattern,
  output logic [15:0]       tri_pattern,
  output logic [3:0]        rbuf_extra_dly,
  output logic              clk_div_inv,
  output logic [7:0]        stat_ctrl,
  output logic              stat_ctrl_stb
);
  logic        we_pat, we_tri, we_dly, we_inv, we_stat;
  logic [15:0] pat_nxt, tri_nxt;
  logic [3:0]  dly_nxt;
  logic        inv_nxt;
  logic [7:0]  stat_nxt;

  always_comb begin
    we_pat  = sel && (offs == 3'd0);
    we_tri  = sel && (offs == 3'd1);
    we_dly  = sel && (offs == 3'd2);
    we_inv  = sel && (offs == 3'd3);
    we_stat = sel && (offs == 3'd4);
    pat_nxt  = we_pat  ? wdata[15:0] : dq_pattern;
    tri_nxt  = we_tri  ? wdata[15:0] : tri_pattern;
    dly_nxt  = we_dly  ? wdata[3:0]  : rbuf_extra_dly;
    inv_nxt  = we_inv  ? wdata[0]    : clk_div_inv;
    stat_nxt = we_stat ? wdata[7:0]  : stat_ctrl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_pattern     <= PATTERN_RST;
      tri_pattern    <= '0;
      rbuf_extra_dly <= '0;
      clk_div_inv    <= 1'b0;
      stat_ctrl      <= '0;
      stat_ctrl_stb  <= 1'b0;
    end else begin
      dq_pattern     <= pat_nxt;
      tri_pattern    <= tri_nxt;
      rbuf_extra_dly <= dly_nxt;
      clk_div_inv    <= inv_nxt;
      stat_ctrl      <= stat_nxt;
      stat_ctrl_stb  <= we_stat;
    end
  end
endmodule

// File: rtl/phy_ctrl_decoder.sv
`timescale 1ns/1ps
module phy_ctrl_decoder #(
  parameter int          ADDR_W    = 10,
  parameter int          DATA_W    = 16,
  parameter int          CHAN_W    = 4,
  parameter logic [15:0] RUN_BASE  = 16'h000,
  parameter logic [15:0] RUN_MASK  = 16'h3f0,
  parameter logic [15:0] FLAG_BASE = 16'h020,
  parameter logic [15:0] FLAG_MASK = 16'h3f0,
  parameter logic [15:0] DATA_BASE = 16'h050,
  parameter logic [15:0] DATA_MASK = 16'h3f8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              run_pulse,
  output logic [CHAN_W-1:0] run_chan,
  output logic              dly_preset_pulse,
  output logic              cmda_en,
  output logic              mem_rst_n,
  output logic              cke_en,
  output logic              zq_cal_rst,
  output logic              dly_cal_rst,
  output logic [15:0]       dq_pattern,
  output logic [15:0]       tri_pattern,
  output logic [3:0]        rbuf_extra_dly,
  output logic              clk_div_inv,
  output logic [7:0]        stat_ctrl,
  output logic              stat_ctrl_stb
);
  import phy_ctrl_pkg::*;

  localparam logic [NUM_FLAGS-1:0] FLAG_RST = NUM_FLAGS'(1) << FL_MEMRST;

  logic rst_n_sync;
  logic run_hit, flag_hit, data_hit;
  logic flag_sel, data_sel;
  logic [NUM_FLAGS-1:0] flags;
  logic run_nxt;
  logic [CHAN_W-1:0] chan_nxt;

  ctrl_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync));

  ctrl_addr_match #(.ADDR_W(ADDR_W), .BASE(RUN_BASE), .MASK(RUN_MASK))
    u_run_match (.en(wr_en), .addr(wr_addr), .hit(run_hit));
  ctrl_addr_match #(.ADDR_W(ADDR_W), .BASE(FLAG_BASE), .MASK(FLAG_MASK))
    u_flag_match (.en(wr_en), .addr(wr_addr), .hit(flag_hit));
  ctrl_addr_match #(.ADDR_W(ADDR_W), .BASE(DATA_BASE), .MASK(DATA_MASK))
    u_data_match (.en(wr_en), .addr(wr_addr), .hit(data_hit));

  // priority: run, then flags, then data registers
  assign flag_sel = flag_hit && !run_hit;
  assign data_sel = data_hit && !run_hit && !flag_hit;

  always_comb begin
    run_nxt  = run_hit;
    chan_nxt = run_hit ? wr_addr[CHAN_W-1:0] : run_chan;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      run_pulse <= 1'b0;
      run_chan  <= '0;
    end else begin
      run_pulse <= run_nxt;
      run_chan  <= chan_nxt;
    end
  end

  ctrl_flag_bank #(.NUM(NUM_FLAGS), .RST_VAL(FLAG_RST)) u_flags (
    .clk(clk), .rst_n(rst_n_sync), .sel(flag_sel), .offs(wr_addr[3:0]),
    .flags(flags), .preset_pulse(dly_preset_pulse)
  );

  assign cmda_en     = flags[FL_CMDA];
  assign mem_rst_n   = ~flags[FL_MEMRST];
  assign cke_en      = flags[FL_CKE];
  assign zq_cal_rst  = flags[FL_ZQRST];
  assign dly_cal_rst = flags[FL_DLYRST];

  ctrl_data_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n_sync), .sel(data_sel), .offs(wr_addr[2:0]),
    .wdata(wr_data), .dq_pattern(dq_pattern), .tri_pattern(tri_pattern),
    .rbuf_extra_dly(rbuf_extra_dly), .clk_div_inv(clk_div_inv),
    .stat_ctrl(stat_ctrl), .stat_ctrl_stb(stat_ctrl_stb)
  );
endmodule

// File: rtl/phy_ctrl_decoder_chk.sv
`timescale 1ns/1ps
module phy_ctrl_decoder_chk #(
  parameter int          ADDR_W    = 10,
  parameter int          DATA_W    = 16,
  parameter int          CHAN_W    = 4,
  parameter logic [15:0] RUN_BASE  = 16'h000,
  parameter logic [15:0] RUN_MASK  = 16'h3f0,
  parameter logic [15:0] FLAG_BASE = 16'h020,
  parameter logic [15:0] FLAG_MASK = 16'h3f0,
  parameter logic [15:0] DATA_BASE = 16'h050,
  parameter logic [15:0] DATA_MASK = 16'h3f8
) (
  input logic              clk,
  input logic              rst_n_sync,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              run_pulse,
  input logic [CHAN_W-1:0] run_chan,
  input logic              dly_preset_pulse,
  input logic              cmda_en,
  input logic              mem_rst_n,
  input logic              cke_en,
  input logic [15:0]       dq_pattern,
  input logic [15:0]       tri_pattern,
  input logic [7:0]        stat_ctrl,
  input logic              stat_ctrl_stb
);
  logic [15:0] a16;
  logic in_run, in_flag, in_data, in_any;
  assign a16     = 16'(wr_addr);
  assign in_run  = wr_en && (((a16 ^ RUN_BASE)  & RUN_MASK)  == 16'h0);
  assign in_flag = wr_en && (((a16 ^ FLAG_BASE) & FLAG_MASK) == 16'h0) && !in_run;
  assign in_data = wr_en && (((a16 ^ DATA_BASE) & DATA_MASK) == 16'h0);
  assign in_any  = in_run || in_flag || in_data;

  p_run_start_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    in_run |=> run_pulse && (run_chan == $past(wr_addr[CHAN_W-1:0])));

  p_run_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !in_run |=> !run_pulse);

  p_cmda_set_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_flag && wr_addr[3:0] == 4'h5) |=> cmda_en);

  p_cke_clr_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_flag && wr_addr[3:0] == 4'h8) |=> !cke_en);

  p_memrst_act_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_flag && wr_addr[3:0] == 4'h7) |=> !mem_rst_n);

  p_preset_src_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    dly_preset_pulse |-> $past(in_flag && wr_addr[3:0] == 4'h0));

  p_stat_stb_r10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    stat_ctrl_stb |-> (stat_ctrl == $past(wr_data[7:0])));

  p_no_match_r1: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wr_en && !in_any) |=> ($stable(dq_pattern) && $stable(tri_pattern) &&
      $stable(stat_ctrl) && $stable({cmda_en, mem_rst_n, cke_en}) &&
      !run_pulse && !dly_preset_pulse && !stat_ctrl_stb));
endmodule

bind phy_ctrl_decoder phy_ctrl_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAN_W(CHAN_W),
  .RUN_BASE(RUN_BASE), .RUN_MASK(RUN_MASK),
  .FLAG_BASE(FLAG_BASE), .FLAG_MASK(FLAG_MASK),
  .DATA_BASE(DATA_BASE), .DATA_MASK(DATA_MASK)
) u_chk (
  .clk(clk), .rst_n_sync(rst_n_sync), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .run_pulse(run_pulse), .run_chan(run_chan),
  .dly_preset_pulse(dly_preset_pulse), .cmda_en(cmda_en),
  .mem_rst_n(mem_rst_n), .cke_en(cke_en), .dq_pattern(dq_pattern),
  .tri_pattern(tri_pattern), .stat_ctrl(stat_ctrl),
  .stat_ctrl_stb(stat_ctrl_stb)
);

// File: tb/phy_ctrl_decoder_bench.sv
`timescale 1ns/1ps
module phy_ctrl_decoder_bench;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 16;
  localparam logic [15:0] RUN_B = 16'h000, RUN_M = 16'h3f0;
  localparam logic [15:0] FLG_B = 16'h020, FLG_M = 16'h3f0;
  localparam logic [15:0] DAT_B = 16'h050, DAT_M = 16'h3f8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic run_pulse, dly_preset_pulse, cmda_en, mem_rst_n, cke_en;
  logic zq_cal_rst, dly_cal_rst, clk_div_inv, stat_ctrl_stb;
  logic [3:0] run_chan, rbuf_extra_dly;
  logic [15:0] dq_pattern, tri_pattern;
  logic [7:0] stat_ctrl;

  always #2.5 clk = ~clk;

  phy_ctrl_decoder u_phy_ctrl_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .run_pulse(run_pulse), .run_chan(run_chan),
    .dly_preset_pulse(dly_preset_pulse), .cmda_en(cmda_en),
    .mem_rst_n(mem_rst_n), .cke_en(cke_en), .zq_cal_rst(zq_cal_rst),
    .dly_cal_rst(dly_cal_rst), .dq_pattern(dq_pattern),
    .tri_pattern(tri_pattern), .rbuf_extra_dly(rbuf_extra_dly),
    .clk_div_inv(clk_div_inv), .stat_ctrl(stat_ctrl),
    .stat_ctrl_stb(stat_ctrl_stb)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // expected state
  logic e_run, e_pre, e_stb, e_inv;
  logic [3:0] e_chan, e_dly;
  logic [4:0] e_fl;            // 0 cmda, 1 mem reset active, 2 cke, 3 zq, 4 dly
  logic [15:0] e_pat, e_tri;
  logic [7:0] e_stat;

  function automatic bit hit(input logic [ADDR_W-1:0] a, input logic [15:0] b,
                             input logic [15:0] m);
    return ((16'(a) ^ b) & m) == 16'h0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    e_run = 0; e_pre = 0; e_stb = 0; e_inv = 0; e_chan = 0; e_dly = 0;
    e_fl = 5'b00010; e_pat = 16'h0055; e_tri = 0; e_stat = 0;
  endtask

  task automatic compare_all(input string req);
    check(run_pulse == e_run, "R2/R3", "run_pulse", 32'(run_pulse), 32'(e_run));
    check(run_chan == e_chan, "R2", "run_chan", 32'(run_chan), 32'(e_chan));
    check(dly_preset_pulse == e_pre, "R5", "preset", 32'(dly_preset_pulse), 32'(e_pre));
    check({dly_cal_rst, zq_cal_rst, cke_en, ~mem_rst_n, cmda_en} == e_fl, "R4",
          "flags", 32'({dly_cal_rst, zq_cal_rst, cke_en, ~mem_rst_n, cmda_en}), 32'(e_fl));
    check(dq_pattern == e_pat, "R7", "dq_pattern", 32'(dq_pattern), 32'(e_pat));
    check(tri_pattern == e_tri, "R8", "tri_pattern", 32'(tri_pattern), 32'(e_tri));
    check(rbuf_extra_dly == e_dly, "R9", "rbuf_extra_dly", 32'(rbuf_extra_dly), 32'(e_dly));
    check(clk_div_inv == e_inv, "R9", "clk_div_inv", 32'(clk_div_inv), 32'(e_inv));
    check(stat_ctrl == e_stat, "R10", "stat_ctrl", 32'(stat_ctrl), 32'(e_stat));
    check(stat_ctrl_stb == e_stb, "R10", "stat_ctrl_stb", 32'(stat_ctrl_stb), 32'(e_stb));
    if (bad != 0 && req.len() > 0) ; // context tag only
  endtask

  // R12: effect of a write is visible at the next negedge (one posedge later)
  task automatic step(input logic en, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d);
    @(negedge clk);
    compare_all("R1 R11 R12");
    e_run = 0; e_pre = 0; e_stb = 0;
    if (en) begin
      if (hit(a, RUN_B, RUN_M)) begin
        e_run = 1; e_chan = a[3:0];
      end else if (hit(a, FLG_B, FLG_M)) begin
        if (a[3:0] == 4'h0) e_pre = 1;
        else if (a[3:0] >= 4'h4 && a[3:0] <= 4'hd) e_fl[(a[3:1]) - 3'd2] = a[0];
      end else if (hit(a, DAT_B, DAT_M)) begin
        case (a[2:0])
          3'd0: e_pat = d;
          3'd1: e_tri = d;
          3'd2: e_dly = d[3:0];
          3'd3: e_inv = d[0];
          3'd4: begin e_stat = d[7:0]; e_stb = 1; end
          default: ;
        endcase
      end
    end
    wr_en = en; wr_addr = a; wr_data = d;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R6 reset values
    check(mem_rst_n == 1'b0, "R6", "mem_rst_n reset", 32'(mem_rst_n), 0);
    check(dq_pattern == 16'h0055, "R6", "pattern reset", 32'(dq_pattern), 32'h55);
    check({cmda_en, cke_en, zq_cal_rst, dly_cal_rst} == 4'h0, "R6", "flags reset",
          32'({cmda_en, cke_en, zq_cal_rst, dly_cal_rst}), 0);
    compare_all("R6");
    // R4 R11: every flag-region address, set then clear
    for (int o = 0; o < 16; o++) step(1'b1, 10'(FLG_B) | 10'(o), 16'hffff);
    for (int o = 15; o >= 0; o--) step(1'b1, 10'(FLG_B) | 10'(o), 16'h0);
    for (int o = 5; o <= 13; o += 2) step(1'b1, 10'(FLG_B) | 10'(o), 16'h0);
    step(1'b1, 10'h022, 16'hffff);  // R11 unused flag offset
    step(1'b1, 10'h02e, 16'hffff);
    // R5 preset pulse back-to-back
    step(1'b1, 10'h020, 16'h1234);
    step(1'b1, 10'h020, 16'h1234);
    // R2 R3 run channels 0, 15, back-to-back, then idle
    step(1'b1, 10'h000, 16'h0);
    step(1'b1, 10'h00f, 16'h0);
    step(1'b1, 10'h007, 16'h0);
    step(1'b0, 10'h003, 16'h0);
    // R7..R10 data registers
    step(1'b1, 10'h050, 16'hbeef);
    step(1'b1, 10'h051, 16'hc3a5);
    step(1'b1, 10'h052, 16'hfff9);
    step(1'b1, 10'h053, 16'hff01);
    step(1'b1, 10'h054, 16'h12a7);
    // R11 unused data offsets; R1 near-miss addresses and strobe low
    step(1'b1, 10'h055, 16'h0);
    step(1'b1, 10'h057, 16'h0);
    step(1'b1, 10'h058, 16'h0);
    step(1'b1, 10'h150, 16'h0);
    step(1'b1, 10'h3ff, 16'h0);
    step(1'b0, 10'h050, 16'h0);
    step(1'b0, 10'h025, 16'h0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [ADDR_W-1:0] a;
      int pick = $urandom % 5;
      case (pick)
        0: a = 10'(RUN_B) | 10'($urandom % 16);
        1, 2: a = 10'(FLG_B) | 10'($urandom % 16);
        3: a = 10'(DAT_B) | 10'($urandom % 8);
        default: a = 10'($urandom);
      endcase
      step(1'($urandom % 4 != 0), a, 16'($urandom));
    end
    step(1'b0, '0, '0);
    step(1'b0, '0, '0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule